// File: doc/BRIEF.md
# Serial Display Command/Data Transmitter

This block drives a write-only 4-wire serial link into a display controller. A host hands it one byte at a time together with a flag that says whether the byte is pixel data or a controller command. The block lowers the chip-select line, sets the data/command line, and clocks the eight bits out most significant bit first. Each bit is placed on the data line while the serial clock is low, and the controller captures it on the rising clock edge. Between transfers the clock rests high. There is no return path from the display.

All link timing is derived from the system clock. Three parameters set the clock half-period, the chip-select setup time and the chip-select hold time, all in system-clock cycles. Each one is raised to the smallest count that still meets the controller's limits at the given system-clock period (`CLK_NS`). Those limits are a half-period of at least 75 ns, at least 75 ns from chip-select falling to the first clock edge, and at least 60 ns from the last rising edge to chip-select rising. Data and data/command setup and hold of 40 ns are then met by construction.

The byte input is a valid/ready stream. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. After raising `in_valid`, the host holds the byte and its flag steady until that cycle. `in_ready` is high while the link is idle, and also in the single cycle that ends the high phase of a byte's last bit. A byte offered in that cycle follows with no chip-select gap. A lower `in_ready` is back-pressure, and no byte is lost or sent twice.

Top module: `disp_spi_tx`

## Requirements
- R1: While reset is held, and right after it is released, `cs_n` is 1, `sclk` is 1 and `in_ready` is 1. Whenever `cs_n` is 1, `sclk` is 1.
- R2: Every accepted byte appears on `sdin` as eight bits, most significant bit first. Each bit is valid at a rising edge of `sclk` while `cs_n` is 0.
- R3: At every rising `sclk` edge of a byte, `dc` equals that byte's `in_is_data` flag, where 1 means display data and 0 means command.
- R4: While `cs_n` stays 0 and `sclk` stays high, `sdin` and `dc` do not change. New values appear only together with a falling `sclk` edge, or during chip-select setup.
- R5: Every low phase of `sclk` lasts exactly H system cycles, where H = max(HALF_CYC, ceil(75/CLK_NS)). So does every high phase between two bits or two bytes of one frame.
- R6: From `cs_n` falling to the first falling `sclk` edge takes exactly S = max(CSS_CYC, ceil(75/CLK_NS)) cycles.
- R7: From the last rising `sclk` edge of a frame to `cs_n` rising takes exactly H + K cycles, where K = max(CSH_CYC, ceil(60/CLK_NS)), and `sclk` stays high throughout.
- R8: A byte accepted in the final cycle of the previous byte's last high phase keeps `cs_n` low. Its first falling edge then comes exactly H cycles after the previous rising edge.
- R9: `in_ready` is 0 whenever `cs_n` is 0, except in the last cycle of the last bit's high phase. A byte held valid under back-pressure is sent exactly once.
- R10: An asynchronous reset during a byte returns `cs_n` and `sclk` to 1 at once and discards the partial byte. The next accepted byte is then sent complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered by the host |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| sclk | output | 1 | Serial clock, rests high |
| sdin | output | 1 | Serial data, most significant bit first |
| dc | output | 1 | Data/command level for the current byte |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is the hand-off between two bytes in one frame. The next byte must arrive in the one cycle where `in_ready` rises at the end of the final high phase. The bench reaches it by keeping `in_valid` high across a burst of three bytes with different data/command flags. It then checks that chip-select rises only once and that the high phase at the byte boundary is still exactly H cycles. A reset applied after the third captured bit shows that the partial byte is dropped.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_HOLD  = 3'd4
  } link_state_e;

  // Whole cycles needed to cover ns nanoseconds at a clock period of per_ns.
  function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned at_least(input int unsigned want, input int unsigned floor_v);
    return (want > floor_v) ? want : floor_v;
  endfunction

endpackage

// File: rtl/disp_spi_timer.sv
module disp_spi_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/disp_spi_shreg.sv
module disp_spi_shreg #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            shift,
  output logic            msb,
  output logic            last_bit
);
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0] data_q;
  logic [CW-1:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      left_q <= '0;
    end else if (load) begin
      data_q <= load_val;
      left_q <= CW'(BITS - 1);
    end else if (shift) begin
      data_q <= {data_q[BITS-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb      = data_q[BITS-1];
  assign last_bit = (left_q == '0);
endmodule

// File: rtl/disp_spi_tx.sv
module disp_spi_tx
  import disp_spi_pkg::*;
#(
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned CSS_CYC  = 5,
  parameter int unsigned CSH_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic       sclk,
  output logic       sdin,
  output logic       dc,
  output logic       cs_n
);
  // Effective counts, raised to meet the controller's minimum times.
  localparam int unsigned HALF_EFF = at_least(HALF_CYC, cycles_for(75, CLK_NS));
  localparam int unsigned CSS_EFF  = at_least(CSS_CYC,  cycles_for(75, CLK_NS));
  localparam int unsigned CSH_EFF  = at_least(CSH_CYC,  cycles_for(60, CLK_NS));
  localparam int unsigned MAX_EFF  = at_least(at_least(HALF_EFF, CSS_EFF), CSH_EFF);
  localparam int unsigned TW       = (MAX_EFF > 1) ? $clog2(MAX_EFF) : 1;
  localparam logic [TW-1:0] HALF_LD = TW'(HALF_EFF - 1);
  localparam logic [TW-1:0] CSS_LD  = TW'(CSS_EFF - 1);
  localparam logic [TW-1:0] CSH_LD  = TW'(CSH_EFF - 1);

  link_state_e   state_q;
  logic          sclk_q, cs_q, dc_q;
  logic          t_load, t_expired;
  logic [TW-1:0] t_val;
  logic          sr_shift, sr_msb, sr_last;
  logic          accept, high_end;

  assign high_end = (state_q == ST_HIGH) && t_expired;
  assign in_ready = (state_q == ST_IDLE) || (high_end && sr_last);
  assign accept   = in_valid && in_ready;
  assign sr_shift = high_end && !sr_last;

  always_comb begin
    t_load = 1'b0;
    t_val  = HALF_LD;
    unique case (state_q)
      ST_IDLE:  if (accept) begin t_load = 1'b1; t_val = CSS_LD; end
      ST_SETUP: if (t_expired) t_load = 1'b1;
      ST_LOW:   if (t_expired) t_load = 1'b1;
      ST_HIGH:  if (t_expired) begin
                  t_load = 1'b1;
                  if (sr_last && !accept) t_val = CSH_LD;
                end
      default:  t_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
      dc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SETUP;
          cs_q    <= 1'b0;
          dc_q    <= in_is_data;
        end
        ST_SETUP: if (t_expired) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
        end
        ST_LOW: if (t_expired) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
        end
        ST_HIGH: if (t_expired) begin
          if (!sr_last || accept) begin
            state_q <= ST_LOW;
            sclk_q  <= 1'b0;
            if (accept) dc_q <= in_is_data;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (t_expired) begin
          state_q <= ST_IDLE;
          cs_q    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  disp_spi_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  disp_spi_shreg #(.BITS(8)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (in_byte),
    .shift    (sr_shift),
    .msb      (sr_msb),
    .last_bit (sr_last)
  );

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign dc   = dc_q;
  assign sdin = sr_msb;
endmodule

// File: rtl/disp_spi_tx_chk.sv
module disp_spi_tx_chk
  import disp_spi_pkg::*;
#(
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned HALF_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic sclk,
  input logic sdin,
  input logic dc,
  input logic cs_n
);
  localparam int unsigned HALF_EFF = at_least(HALF_CYC, cycles_for(75, CLK_NS));

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= '0;
    else if (sclk)             low_run <= '0;
    else if (low_run != '1)    low_run <= low_run + 1'b1;
  end

  assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_bits_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sclk && $past(sclk)) |-> ($stable(sdin) && $stable(dc)));

  assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !cs_n) |-> (low_run == 16'(HALF_EFF)));

  assert_ready_only_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cs_n) |-> sclk);

  assert_cs_rise_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk && $past(sclk)));
endmodule

bind disp_spi_tx disp_spi_tx_chk #(.CLK_NS(CLK_NS), .HALF_CYC(HALF_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .sclk     (sclk),
  .sdin     (sdin),
  .dc       (dc),
  .cs_n     (cs_n)
);

// File: tb/disp_spi_tx_bench.sv
module disp_spi_tx_bench;
  // 20 ns clock; expected counts worked out from the requirements:
  // H = max(2, ceil(75/20)=4) = 4, S = max(5, 4) = 5, K = max(1, ceil(60/20)=3) = 3
  localparam int EXP_H = 4;
  localparam int EXP_S = 5;
  localparam int EXP_K = 3;

  // {is_data, byte}
  localparam logic [8:0] VEC [0:5] = '{
    9'h0AE, 9'h1FF, 9'h000, 9'h181, 9'h07E, 9'h1A5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_is_data = 1'b0;
  logic in_ready, sclk, sdin, dc, cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_spi_tx #(.CLK_NS(20), .HALF_CYC(2), .CSS_CYC(5), .CSH_CYC(1)) u_disp_spi_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data),
    .sclk(sclk), .sdin(sdin), .dc(dc), .cs_n(cs_n)
  );

  // Port-level link monitor acting as the receiving controller.
  int t = 0, t_csf = 0, t_edge = 0, t_rise = 0;
  int setup_meas = 0, hold_meas = 0, phase_err = 0, dc_err = 0;
  int nbits = 0, ncap = 0, cs_rises = 0;
  bit pend = 1'b0, prev_s = 1'b1, prev_c = 1'b1, dc_first = 1'b0;
  logic [7:0] shreg = 8'h00;
  logic [7:0] cap_byte [0:31];
  bit         cap_dc   [0:31];

  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; pend = 1'b0; prev_s = 1'b1; prev_c = 1'b1;
    end else begin
      t++;
      if (prev_c && !cs_n) begin t_csf = t; pend = 1'b1; end
      if (prev_s && !sclk && !cs_n) begin
        if (pend) begin setup_meas = t - t_csf; pend = 1'b0; end
        else if (t - t_edge != EXP_H) phase_err++;
        t_edge = t;
      end
      if (!prev_s && sclk) begin
        if (t - t_edge != EXP_H) phase_err++;
        t_edge = t; t_rise = t;
        shreg = {shreg[6:0], sdin};
        if (nbits == 0) dc_first = dc;
        else if (dc != dc_first) dc_err++;
        nbits++;
        if (nbits == 8) begin
          if (ncap < 32) begin cap_byte[ncap] = shreg; cap_dc[ncap] = dc_first; end
          ncap++; nbits = 0;
        end
      end
      if (!prev_c && cs_n) begin hold_meas = t - t_rise; cs_rises++; nbits = 0; end
      prev_s = sclk; prev_c = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic d);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 idle in reset", {cs_n, sclk}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && in_ready, "R1 idle after reset", {cs_n, sclk, in_ready}, 3'b111);

    // Table walk: single-byte frames.
    for (int i = 0; i < 6; i++) begin
      int base;
      base = ncap;
      phase_err = 0; dc_err = 0;
      send(VEC[i][7:0], VEC[i][8]);
      in_valid = 1'b0;
      wait_idle();
      chk(ncap == base + 1, "R9 one byte per accept", ncap - base, 1);
      chk(cap_byte[base] == VEC[i][7:0], "R2 byte msb first", cap_byte[base], VEC[i][7:0]);
      chk(cap_dc[base] == VEC[i][8] && dc_err == 0, "R3 dc level", cap_dc[base], VEC[i][8]);
      chk(phase_err == 0, "R5 phase widths", phase_err, 0);
      chk(setup_meas == EXP_S, "R6 cs setup", setup_meas, EXP_S);
      chk(hold_meas == EXP_H + EXP_K, "R7 cs hold", hold_meas, EXP_H + EXP_K);
    end

    // Burst of three with valid held: one frame, no gap.
    begin
      int base, rises;
      base = ncap; rises = cs_rises; phase_err = 0; dc_err = 0;
      send(8'h3C, 1'b0);
      chk(in_ready == 1'b0, "R9 back-pressure mid frame", in_ready, 0);
      send(8'hC3, 1'b1);
      send(8'h5A, 1'b0);
      in_valid = 1'b0;
      wait_idle();
      chk(cs_rises == rises + 1, "R8 single cs frame", cs_rises - rises, 1);
      chk(ncap == base + 3, "R9 no loss or duplicate", ncap - base, 3);
      chk(cap_byte[base] == 8'h3C && cap_dc[base] == 1'b0, "R8 burst byte0", cap_byte[base], 8'h3C);
      chk(cap_byte[base+1] == 8'hC3 && cap_dc[base+1] == 1'b1, "R3 burst byte1 dc", cap_byte[base+1], 8'hC3);
      chk(cap_byte[base+2] == 8'h5A && cap_dc[base+2] == 1'b0, "R8 burst byte2", cap_byte[base+2], 8'h5A);
      chk(phase_err == 0 && dc_err == 0, "R8 boundary phase width", phase_err, 0);
    end

    // Reset during a byte.
    begin
      int base;
      send(8'hA5, 1'b1);
      in_valid = 1'b0;
      while (nbits < 3) @(negedge clk);
      base = ncap;
      rst_n = 1'b0;
      #1;
      chk(cs_n && sclk && in_ready, "R10 idle at once on reset", {cs_n, sclk, in_ready}, 3'b111);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      phase_err = 0;
      send(8'h96, 1'b0);
      in_valid = 1'b0;
      wait_idle();
      chk(ncap == base + 1, "R10 partial byte dropped", ncap - base, 1);
      chk(cap_byte[base] == 8'h96 && cap_dc[base] == 1'b0, "R10 next byte whole", cap_byte[base], 8'h96);
      chk(setup_meas == EXP_S && phase_err == 0, "R6 setup after reset", setup_meas, EXP_S);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule